// File: doc/BRIEF.md
# Two-Class Single-Cycle Register Processor

This block is a small processor core. Each clock cycle it fetches one 32-bit word from an internal instruction store, decodes it, computes the result and writes that result into a 32 x 32-bit register file. The core has only two ports, a clock and a reset. The instruction store and the register file are reached by hierarchy: the testbench loads programs into the store and reads the registers back to check them.

There are two classes of instruction, selected by the 6-bit opcode in bits 31:26. The all-ones opcode loads a signed 16-bit constant into a register. The all-zeros opcode runs a register-to-register operation, and the 6-bit function code in bits 5:0 picks that operation. The destination index is in bits 25:21, source 1 in bits 20:16, source 2 in bits 15:11 and the shift count in bits 10:6. Any other opcode, or an unlisted function code, leaves the register file untouched.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high the program counter is 0 and all 32 registers read 0. After `rst` falls, the first rising clock edge executes the instruction at word 0.
- R2: One instruction completes per rising edge, taken from consecutive word indices. The index wraps from 63 to 0, and a word that was never loaded reads as zero.
- R3: Opcode 111111 writes bits 15:0, sign-extended to 32 bits, into the register named by bits 25:21. The source fields are ignored.
- R4: Opcode 000000 with function 100000 writes src1 + src2, and with function 100010 writes src1 - src2, both modulo 2^32.
- R5: Opcode 000000 with function 100100 writes the bitwise AND of src1 and src2, and with function 100101 writes their bitwise OR.
- R6: Opcode 000000 with function 000000 shifts src1 left by bits 10:6, and with function 000010 shifts it right logically by bits 10:6, filling with zeros.
- R7: An opcode other than 000000 or 111111 changes no register.
- R8: Opcode 000000 with a function code outside the six listed changes no register.
- R9: Register 0 holds a written value like any other register.
- R10: Source operands are read before the write of the same cycle, so an instruction that reads its own destination sees the old value, and the next instruction sees the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every instruction completes on a rising edge |
| rst | input | 1 | Asynchronous active-high reset of the program counter and registers |

## Verification
The assertions assume a program is already in the instruction store when `rst` falls, and that `rst` is only changed away from the rising clock edge. The bench loads each program while reset is held and changes `rst` only on falling edges. The assertions also treat every bit pattern of a word as a possible instruction. The random programs therefore include illegal opcodes, unlisted function codes and shift words with arbitrary counts. Register indices are drawn from a small range so that results are read back by later instructions.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int XLEN    = 32;
  localparam int NREGS   = 32;
  localparam int RIDX_W  = $clog2(NREGS);
  localparam int SHAMT_W = 5;
  localparam int IMM_W   = 16;

  localparam logic [5:0] OPC_LDI = 6'b111111;
  localparam logic [5:0] OPC_REG = 6'b000000;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLL = 6'b000000;
  localparam logic [5:0] FN_SRL = 6'b000010;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLL, ALU_SRL, ALU_PASSB
  } alu_op_e;

  typedef struct packed {
    logic    wr_en;
    logic    b_is_imm;
    alu_op_e op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b,
                                               input logic [SHAMT_W-1:0] sh);
    logic [XLEN-1:0] r;
    case (op)
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SLL: r = a << sh;
      ALU_SRL: r = a >> sh;
      default: r = b;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sc_fetch.sv
module sc_fetch #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int PC_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PC_W-1:0]  pc,
  output logic [WIDTH-1:0] instr
);
  // Program store; filled by the testbench through hierarchy.
  logic [WIDTH-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  // DEPTH is a power of two, so the index wraps naturally.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) pc <= '0;
    else     pc <= pc + PC_W'(1);
  end

  assign instr = mem[pc];
endmodule

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl.wr_en    = 1'b0;
    ctrl.b_is_imm = 1'b0;
    ctrl.op       = ALU_PASSB;
    if (opcode == OPC_LDI) begin
      ctrl.wr_en    = 1'b1;
      ctrl.b_is_imm = 1'b1;
      ctrl.op       = ALU_PASSB;
    end else if (opcode == OPC_REG) begin
      ctrl.wr_en = 1'b1;
      case (funct)
        FN_ADD:  ctrl.op = ALU_ADD;
        FN_SUB:  ctrl.op = ALU_SUB;
        FN_AND:  ctrl.op = ALU_AND;
        FN_OR:   ctrl.op = ALU_OR;
        FN_SLL:  ctrl.op = ALU_SLL;
        FN_SRL:  ctrl.op = ALU_SRL;
        default: ctrl.wr_en = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/sc_exec.sv
module sc_exec
  import sc_core_pkg::*;
(
  input  ctrl_t               ctrl,
  input  logic [XLEN-1:0]     src1,
  input  logic [XLEN-1:0]     src2,
  input  logic [IMM_W-1:0]    imm,
  input  logic [SHAMT_W-1:0]  shamt,
  output logic [XLEN-1:0]     result
);
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] opnd_b;

  assign imm_ext = sext_imm(imm);
  assign opnd_b  = ctrl.b_is_imm ? imm_ext : src2;
  assign result  = alu_eval(ctrl.op, src1, opnd_b, shamt);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  localparam int PC_W      = $clog2(IMEM_DEPTH)
) (
  input logic clk,
  input logic rst
);
  logic [PC_W-1:0]   pc;
  logic [XLEN-1:0]   instr;
  logic [5:0]        f_opc;
  logic [RIDX_W-1:0] f_dst;
  logic [RIDX_W-1:0] f_src1;
  logic [RIDX_W-1:0] f_src2;
  logic [SHAMT_W-1:0] f_shamt;
  logic [5:0]        f_funct;
  logic [IMM_W-1:0]  f_imm;
  ctrl_t             ctrl;
  logic [XLEN-1:0]   rs1_val;
  logic [XLEN-1:0]   rs2_val;
  logic [XLEN-1:0]   rf_wd;
  logic              rf_we;

  sc_fetch #(.DEPTH(IMEM_DEPTH), .WIDTH(XLEN)) u_fetch (
    .clk(clk), .rst(rst), .pc(pc), .instr(instr)
  );

  assign f_opc   = instr[31:26];
  assign f_dst   = instr[25:21];
  assign f_src1  = instr[20:16];
  assign f_src2  = instr[15:11];
  assign f_shamt = instr[10:6];
  assign f_funct = instr[5:0];
  assign f_imm   = instr[15:0];

  sc_decode u_dec (.opcode(f_opc), .funct(f_funct), .ctrl(ctrl));

  assign rf_we = ctrl.wr_en;

  sc_regfile #(.NREG(NREGS), .W(XLEN)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(f_src1), .ra2(f_src2), .rd1(rs1_val), .rd2(rs2_val),
    .we(rf_we), .wa(f_dst), .wd(rf_wd)
  );

  sc_exec u_exe (
    .ctrl(ctrl), .src1(rs1_val), .src2(rs2_val),
    .imm(f_imm), .shamt(f_shamt), .result(rf_wd)
  );
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter int PC_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] pc,
  input logic [31:0]     instr,
  input logic            rf_we,
  input logic [31:0]     rf_wd,
  input logic [31:0]     rs1_val
);
  logic [5:0] opc;
  logic [5:0] fn;
  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> PC_W'(pc - $past(pc)) == PC_W'(1));

  p_ldi_sext_r3: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'b111111) |-> (rf_we && rf_wd == {{16{instr[15]}}, instr[15:0]}));

  p_bad_opcode_r7: assert property (@(posedge clk) disable iff (rst)
    (opc != 6'b000000 && opc != 6'b111111) |-> !rf_we);

  p_bad_funct_r8: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'b000000 && fn != 6'b100000 && fn != 6'b100010 && fn != 6'b100100 &&
     fn != 6'b100101 && fn != 6'b000000 && fn != 6'b000010) |-> !rf_we);

  p_shift_left_r6: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'b000000 && fn == 6'b000000) |-> (rf_we && rf_wd == (rs1_val << instr[10:6])));

  p_shift_right_r6: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'b000000 && fn == 6'b000010) |-> (rf_we && rf_wd == (rs1_val >> instr[10:6])));
endmodule

bind sc_core sc_core_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .pc(pc), .instr(instr),
  .rf_we(rf_we), .rf_wd(rf_wd), .rs1_val(rs1_val)
);

// File: tb/test_sc_core.sv
module test_sc_core;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  sc_core i_sc_core (.clk(clk), .rst(rst));

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] prog  [DEPTH];
  logic [31:0] model [32];

  function automatic logic [31:0] mk_r(input int d, input int a, input int b,
                                       input int sh, input logic [5:0] fn);
    return {6'b000000, 5'(d), 5'(a), 5'(b), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] mk_li(input int d, input logic [15:0] v);
    return {6'b111111, 5'(d), 5'd0, v};
  endfunction

  function automatic string req_tag(input logic [31:0] w);
    if (w[31:26] == 6'h3f) return "R3";
    if (w[31:26] != 6'h00) return "R7";
    case (w[5:0])
      6'h20, 6'h22: return "R4";
      6'h24, 6'h25: return "R5";
      6'h00, 6'h02: return "R6";
      default:      return "R8";
    endcase
  endfunction

  // Reference step: reads the sources before any update (R10).
  task automatic model_step(input logic [31:0] w);
    logic [31:0] a, b, r;
    logic ok;
    a  = model[w[20:16]];
    b  = model[w[15:11]];
    ok = 1'b1;
    r  = '0;
    if (w[31:26] == 6'h3f) begin
      r = {{16{w[15]}}, w[15:0]};
    end else if (w[31:26] == 6'h00) begin
      case (w[5:0])
        6'h20: r = a + b;
        6'h22: r = a + ~b + 32'd1;
        6'h24: r = a & b;
        6'h25: r = a | b;
        6'h00: r = a << w[10:6];
        6'h02: r = a >> w[10:6];
        default: ok = 1'b0;
      endcase
    end else begin
      ok = 1'b0;
    end
    if (ok) model[w[25:21]] = r;
  endtask

  task automatic compare_all(input string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < 32; i++)
      if (bad < 0 && i_sc_core.u_rf.regs[i] !== model[i]) bad = i;
    n_checks++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s: r%0d actual %h expected %h", tag, bad,
               i_sc_core.u_rf.regs[bad], model[bad]);
    end
  endtask

  task automatic load_and_reset();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) i_sc_core.u_fetch.mem[i] = prog[i];
    for (int i = 0; i < 32; i++) model[i] = '0;
    @(negedge clk);
    @(negedge clk);
    compare_all("R1 reset clears registers");
    rst = 1'b0;
  endtask

  task automatic run(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      model_step(prog[c % DEPTH]);
      @(negedge clk);
      compare_all($sformatf("%s word %0d (R2 R10)", req_tag(prog[c % DEPTH]), c % DEPTH));
    end
  endtask

  function automatic logic [31:0] rand_instr();
    int k, d, a, b;
    logic [5:0] fn, op;
    k = int'($urandom_range(0, 11));
    d = int'($urandom_range(0, 7));
    a = int'($urandom_range(0, 7));
    b = int'($urandom_range(0, 7));
    case (k)
      0, 1, 2: return mk_li(d, 16'($urandom));
      3: return mk_r(d, a, b, 0, 6'h20);
      4: return mk_r(d, a, b, 0, 6'h22);
      5: return mk_r(d, a, b, 0, 6'h24);
      6: return mk_r(d, a, b, 0, 6'h25);
      7: return mk_r(d, a, 0, int'($urandom_range(0, 31)), 6'h00);
      8: return mk_r(d, a, 0, int'($urandom_range(0, 31)), 6'h02);
      9: begin
        op = 6'($urandom_range(1, 62));
        return {op, 26'($urandom)};
      end
      default: begin
        fn = 6'h01;
        if ($urandom_range(0, 1) == 0) fn = 6'h3f;
        return mk_r(d, a, b, 0, fn);
      end
    endcase
  endfunction

  initial begin
    void'($urandom(32'h1a2b3c));
    for (int i = 0; i < DEPTH; i++) prog[i] = '0;
    // Directed program: corner cases.
    prog[0]  = mk_li(1, 16'h8001);          // R3 negative sign-extend
    prog[1]  = mk_li(2, 16'h7fff);          // R3 positive
    prog[2]  = mk_li(0, 16'h0005);          // R9 write r0
    prog[3]  = mk_r(3, 0, 0, 0, 6'h20);     // R9 r0 read back
    prog[4]  = mk_r(4, 0, 2, 0, 6'h22);     // R4 underflow
    prog[5]  = mk_r(5, 1, 2, 0, 6'h20);     // R4 add
    prog[6]  = mk_r(6, 1, 2, 0, 6'h24);     // R5 and
    prog[7]  = mk_r(7, 1, 2, 0, 6'h25);     // R5 or
    prog[8]  = mk_r(8, 1, 0, 31, 6'h00);    // R6 sll by 31
    prog[9]  = mk_r(9, 1, 0, 31, 6'h02);    // R6 srl by 31, zero fill
    prog[10] = mk_r(10, 1, 0, 0, 6'h02);    // R6 shift by 0
    prog[11] = {6'b101010, 26'h3ffffff};    // R7 illegal opcode
    prog[12] = mk_r(1, 2, 2, 0, 6'h21);     // R8 unlisted funct
    prog[13] = mk_r(2, 2, 2, 0, 6'h20);     // R10 read own dest
    prog[14] = mk_r(11, 2, 2, 0, 6'h20);    // R10 next sees new value
    prog[15] = {6'b111111, 5'd12, 5'd31, 16'h0000}; // R3 src field ignored
    load_and_reset();
    run(DEPTH + 20);                        // R2 wrap, unloaded words read zero

    // Mid-run reset restarts at word 0 (R1).
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < DEPTH; i++) prog[i] = rand_instr();
      load_and_reset();
      run(DEPTH + 8);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int t = 0; t < 100000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule